// File: doc/BRIEF.md
# Pin I/O Controller with Four-Way Pin Interrupts

This block is a memory-mapped general-purpose pin controller for up to 32 pins. Software reaches it through a simple 32-bit register bus. For each pin it sets an input gate, a drive enable, a drive value and an inversion mask. The pad output is the drive value XOR the inversion mask.

Each pin watches its gated, synchronised input for four separate conditions: a rising edge, a falling edge, a high level and a low level. Each condition has its own enable register and its own sticky pending register. A pending bit sets whenever its condition is seen, whatever the state of its enable. Software clears a pending bit by writing 1 to it. Each pin has its own interrupt line toward a parent interrupt controller. That line is high when any of the four conditions has both its pending bit and its enable bit set.

The request side accepts one access in every cycle, so `req_ready_o` is tied high and there is no back-pressure. A read answers with `rsp_valid_o` and `rsp_rdata_o` in the cycle after the request is accepted. The response has no ready signal: the requester must take the data in that cycle.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset all registers read 0, `pad_oe_o` is 0, `pad_out_o` is 0 and `irq_o` is 0.
- R2: `pad_out_o` equals drive value (0x0C) XOR inversion mask (0x10), and `pad_oe_o` equals drive enable (0x08). Both take their new value in the cycle after the write.
- R3: Reading the drive value register (0x0C) returns the last value written to it, not the inverted pad level.
- R4: The input register (0x00) reads the pad input after a two-flop synchroniser, ANDed with the input gate (0x04).
- R5: Rise pending (0x18) sets on a 0-to-1 change of the gated input. Fall pending (0x20) sets on a 1-to-0 change. Each stays set after the pin settles until software clears it.
- R6: High pending (0x28) and low pending (0x30) set in every cycle that their level holds on the gated input. When the level persists, a clear leaves the bit at 1.
- R7: Writing 1 to a pending bit clears it. Writing 0 to a pending bit leaves it unchanged.
- R8: When a clear write and a new detection of the same pending bit happen in the same cycle, the bit stays set.
- R9: Pending bits set whatever their enable. The enables are rise 0x14, fall 0x1C, high 0x24 and low 0x2C. `irq_o[i]` is the OR over the four conditions of pending[i] AND enable[i]. Writing 0 to all four enables drops every line.
- R10: `req_ready_o` is always 1. A read gives `rsp_valid_o` high with its data one cycle later. Unmapped addresses read 0. A write to the input register or to an unmapped address changes nothing.
- R11: Where the input gate bit is 0, the gated input is 0. Rise and high pending then do not set for that pin, and low pending does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Bus request present |
| req_ready_o | output | 1 | Request accepted (always 1) |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte address, word aligned |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| pad_in_i | input | NPIN | Asynchronous pad levels |
| pad_out_o | output | NPIN | Pad output level |
| pad_oe_o | output | NPIN | Pad output enable |
| irq_o | output | NPIN | Per-pin interrupt lines |

## Verification
The bench times a clear write so that it lands in the same cycle as a fresh rising-edge detection. A design in which the clear wins would drop that interrupt and read the bit as 0. It clears a high-level pending bit while the pin stays high: a design that treats levels as edges would leave the bit at 0. It also writes 0 to pending registers, where a design that clears on any write would lose the bits. The bench checks that gated-off pins still collect low-level pending, that rise pending stays set after the pin falls, and that drive value readback ignores the inversion mask. A design with the wrong XOR or the wrong readback source fails these table checks.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned N_TRIG = 4;

  typedef enum logic [1:0] {
    TRIG_RISE = 2'd0,
    TRIG_FALL = 2'd1,
    TRIG_HIGH = 2'd2,
    TRIG_LOW  = 2'd3
  } trig_e;

  localparam logic [ADDR_W-1:0] A_PIN_IN   = 8'h00;
  localparam logic [ADDR_W-1:0] A_IN_GATE  = 8'h04;
  localparam logic [ADDR_W-1:0] A_DRV_EN   = 8'h08;
  localparam logic [ADDR_W-1:0] A_DRV_VAL  = 8'h0C;
  localparam logic [ADDR_W-1:0] A_DRV_INV  = 8'h10;
  localparam logic [ADDR_W-1:0] A_TRIG_BASE = 8'h14;
  localparam logic [ADDR_W-1:0] A_TRIG_STEP = 8'h08;

  function automatic logic [ADDR_W-1:0] en_addr(input int unsigned t);
    return A_TRIG_BASE + ADDR_W'(t) * A_TRIG_STEP;
  endfunction

  function automatic logic [ADDR_W-1:0] pend_addr(input int unsigned t);
    return A_TRIG_BASE + ADDR_W'(t) * A_TRIG_STEP + 8'h04;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= async_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_cond_detect.sv
module gpio_cond_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [W-1:0]              lvl_i,
  output logic [N_TRIG-1:0][W-1:0]  det_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  always_comb begin
    det_o            = '0;
    det_o[TRIG_RISE] = lvl_i & ~prev_q;
    det_o[TRIG_FALL] = ~lvl_i & prev_q;
    det_o[TRIG_HIGH] = lvl_i;
    det_o[TRIG_LOW]  = ~lvl_i;
  end
endmodule

// File: rtl/gpio_trig_slot.sv
module gpio_trig_slot #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_we_i,
  input  logic [W-1:0] en_wdata_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] det_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] en_q;
  logic [W-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_we_i) en_q <= en_wdata_i;
      pend_q <= (pend_q & ~clr_i) | det_i;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign hit_o  = en_q & pend_q;

  // R5: bits not cleared stay set
  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i)));

  // R8: a detection always lands, even against a clear
  p_det_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(det_i)) == $past(det_i)));

  // R7: nothing sets without a detection
  p_no_stray_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(det_i)) == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPIN        = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_wr_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [REG_W-1:0]  req_wdata_i,
  output logic              rsp_valid_o,
  output logic [REG_W-1:0]  rsp_rdata_o,
  input  logic [NPIN-1:0]   pad_in_i,
  output logic [NPIN-1:0]   pad_out_o,
  output logic [NPIN-1:0]   pad_oe_o,
  output logic [NPIN-1:0]   irq_o
);
  logic [NPIN-1:0] gate_q, oe_q, val_q, inv_q;
  logic [NPIN-1:0] sync_lvl, gated_lvl;
  logic [N_TRIG-1:0][NPIN-1:0] det, slot_en, slot_pend, slot_hit, slot_clr;
  logic [N_TRIG-1:0] slot_we;
  logic wr_hit, rd_hit;
  logic [REG_W-1:0] rd_next;
  logic [NPIN-1:0] wdata_pin;
  logic [NPIN-1:0] pend_any;

  assign req_ready_o = 1'b1;
  assign wr_hit      = req_valid_i & req_wr_i;
  assign rd_hit      = req_valid_i & ~req_wr_i;
  assign wdata_pin   = req_wdata_i[NPIN-1:0];

  // control registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= '0;
      oe_q   <= '0;
      val_q  <= '0;
      inv_q  <= '0;
    end else if (wr_hit) begin
      case (req_addr_i)
        A_IN_GATE: gate_q <= wdata_pin;
        A_DRV_EN:  oe_q   <= wdata_pin;
        A_DRV_VAL: val_q  <= wdata_pin;
        A_DRV_INV: inv_q  <= wdata_pin;
        default:   ;
      endcase
    end
  end

  assign pad_out_o = val_q ^ inv_q;
  assign pad_oe_o  = oe_q;

  // input path
  gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pad_in_i),
    .sync_o  (sync_lvl)
  );

  assign gated_lvl = sync_lvl & gate_q;

  gpio_cond_detect #(.W(NPIN)) u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (gated_lvl),
    .det_o  (det)
  );

  // one enable/pending slot per trigger condition
  for (genvar t = 0; t < N_TRIG; t++) begin : g_slot
    assign slot_we[t]  = wr_hit && (req_addr_i == en_addr(t));
    assign slot_clr[t] = (wr_hit && (req_addr_i == pend_addr(t))) ? wdata_pin : '0;

    gpio_trig_slot #(.W(NPIN)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_we_i    (slot_we[t]),
      .en_wdata_i (wdata_pin),
      .clr_i      (slot_clr[t]),
      .det_i      (det[t]),
      .en_o       (slot_en[t]),
      .pend_o     (slot_pend[t]),
      .hit_o      (slot_hit[t])
    );
  end

  always_comb begin
    irq_o    = '0;
    pend_any = '0;
    for (int t = 0; t < N_TRIG; t++) begin
      irq_o    = irq_o | slot_hit[t];
      pend_any = pend_any | slot_pend[t];
    end
  end

  // read path
  always_comb begin
    rd_next = '0;
    case (req_addr_i)
      A_PIN_IN:  rd_next[NPIN-1:0] = gated_lvl;
      A_IN_GATE: rd_next[NPIN-1:0] = gate_q;
      A_DRV_EN:  rd_next[NPIN-1:0] = oe_q;
      A_DRV_VAL: rd_next[NPIN-1:0] = val_q;
      A_DRV_INV: rd_next[NPIN-1:0] = inv_q;
      default: begin
        for (int t = 0; t < N_TRIG; t++) begin
          if (req_addr_i == en_addr(t))   rd_next[NPIN-1:0] = slot_en[t];
          if (req_addr_i == pend_addr(t)) rd_next[NPIN-1:0] = slot_pend[t];
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd_hit;
      rsp_rdata_o <= rd_hit ? rd_next : '0;
    end
  end

  // R9: a line never rises without some pending bit behind it
  p_irq_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & ~pend_any) == '0));

  // R2: pad level follows a drive value write one cycle later
  p_drive_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && req_addr_i == A_DRV_VAL) |=> (pad_out_o == ($past(wdata_pin) ^ inv_q)));

  // R10: every read answers exactly one cycle later
  p_rsp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (rsp_valid_o == $past(rd_hit)));
endmodule

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_wr = 1'b0;
  logic        req_ready;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [31:0] pad_in = '0, pad_out, pad_oe, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  gpio_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_wr_i(req_wr),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe), .irq_o(irq)
  );

  // register offsets as listed in the requirements
  localparam logic [7:0] IN = 8'h00, GATE = 8'h04, OE = 8'h08, VAL = 8'h0C, INV = 8'h10;
  localparam logic [7:0] RISE_EN = 8'h14, RISE_P = 8'h18, FALL_EN = 8'h1C, FALL_P = 8'h20;
  localparam logic [7:0] HIGH_EN = 8'h24, HIGH_P = 8'h28, LOW_EN = 8'h2C, LOW_P = 8'h30;

  // {drive value, inversion, drive enable, expected pad_out}
  localparam logic [127:0] VEC [5] = '{
    {32'h0000FFFF, 32'h00000000, 32'hFFFFFFFF, 32'h0000FFFF},
    {32'h0000FFFF, 32'hFFFFFFFF, 32'h0F0F0F0F, 32'hFFFF0000},
    {32'hA5A5A5A5, 32'h0F0F0F0F, 32'h00000000, 32'hAAAAAAAA},
    {32'h12345678, 32'hFFFF0000, 32'h80000001, 32'hEDCB5678},
    {32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_wr = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_wr = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    d = rsp_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 pad_out", pad_out, 32'h0);
    chk("R1 irq", irq, 32'h0);
    chk("R10 ready", {31'd0, req_ready}, 32'd1);
    rd_chk("R1 drive value", VAL, 32'h0);
    rd_chk("R1 rise enable", RISE_EN, 32'h0);

    // R2 / R3 table walk
    for (int i = 0; i < 5; i++) begin
      wr(INV, VEC[i][95:64]);
      wr(OE,  VEC[i][63:32]);
      wr(VAL, VEC[i][127:96]);
      chk("R2 pad_out", pad_out, VEC[i][31:0]);
      chk("R2 pad_oe", pad_oe, VEC[i][63:32]);
      rd_chk("R3 drive readback", VAL, VEC[i][127:96]);
    end

    // R10 unmapped and read-only
    rd_chk("R10 unmapped read", 8'hFC, 32'h0);
    wr(8'hFC, 32'hFFFFFFFF);
    wr(IN, 32'hFFFFFFFF);
    rd_chk("R10 write to input ignored", IN, 32'h0);
    rd_chk("R10 unmapped write ignored", GATE, 32'h0);

    // R11 gate closed: only low pending collects
    pad_in = 32'h0000_0005;
    settle();
    rd_chk("R11 gated input", IN, 32'h0);
    rd_chk("R11 rise blocked", RISE_P, 32'h0);
    rd_chk("R11 high blocked", HIGH_P, 32'h0);
    rd_chk("R11 low collects", LOW_P, 32'hFFFFFFFF);

    // R4 / R5 / R6 gate open
    wr(GATE, 32'hFFFFFFFF);
    settle();
    rd_chk("R4 input value", IN, 32'h5);
    rd_chk("R5 rise pending", RISE_P, 32'h5);
    rd_chk("R6 high pending", HIGH_P, 32'h5);

    // R7 write-0 no effect, write-1 clears
    wr(RISE_P, 32'h0);
    rd_chk("R7 write zero", RISE_P, 32'h5);
    wr(RISE_P, 32'h1);
    rd_chk("R7 write one clears", RISE_P, 32'h4);

    // R6 level re-sets after clear
    wr(HIGH_P, 32'hFFFFFFFF);
    rd_chk("R6 high persists", HIGH_P, 32'h5);

    // R5 fall and stickiness
    pad_in = 32'h0;
    settle();
    rd_chk("R5 fall pending", FALL_P, 32'h5);
    rd_chk("R5 rise sticky", RISE_P, 32'h4);

    // R8 clear collides with a fresh rising edge on pin 0
    @(negedge clk);
    pad_in = 32'h1;
    @(negedge clk);
    wr(RISE_P, 32'h1);
    rd_chk("R8 detect wins", RISE_P, 32'h5);

    // R9 interrupt lines
    chk("R9 no enable no irq", irq, 32'h0);
    wr(RISE_EN, 32'h1);
    chk("R9 rise irq", irq, 32'h1);
    wr(LOW_EN, 32'h2);
    chk("R9 low irq", irq, 32'h3);
    wr(RISE_EN, 32'h0);
    wr(FALL_EN, 32'h0);
    wr(HIGH_EN, 32'h0);
    wr(LOW_EN, 32'h0);
    chk("R9 all enables off", irq, 32'h0);
    rd_chk("R9 pending kept", RISE_P, 32'h5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule